// File: doc/BRIEF.md
# Serial-Loaded DAC Setting Register

This block holds the 8-bit code for a current-output DAC. A host writes and reads that code over a three-wire serial link: an active-low select, a shift clock and a serial data line in. A separate serial data line out is three-stated whenever the block is not selected.

While the select is held low, the host clocks a new word in, most-significant bit first. In the same transfer, the block clocks the code it currently holds back out, also most-significant bit first, so every write is also a read. When the select is released, the new word replaces the held code, but only if exactly eight clock pulses arrived.

The register starts at mid-scale after reset. An active-low shutdown input turns off the analog side through a status output, and it leaves the held code untouched. All pins are oversampled by a system clock through synchronizer stages.

Top module: `serial_dac_reg`

## Requirements
- R1: After reset, `dac_code` is 0x80, `sdo_oe` is 0, `sdo` is 0 and `dac_active` is 0.
- R2: The data input is sampled on each rising edge of `sclk` while `cs_n` is low. The first bit sampled is bit 7 of the new word. When `cs_n` rises after exactly 8 rising edges, the word becomes `dac_code`.
- R3: A transfer with any number of rising `sclk` edges other than 8, including 0, 7 and 9, leaves `dac_code` unchanged.
- R4: `sclk` and `sdi` activity while `cs_n` is high has no effect on `dac_code`.
- R5: During a transfer, `sdo` presents the code held when `cs_n` fell, most-significant bit first. Bit 7 is driven as soon as the select is seen low, and the next bit follows each falling edge of `sclk`.
- R6: While `cs_n` is high, `sdo_oe` is 0 and `sdo` is 0. While it is low, `sdo_oe` is 1.
- R7: `shdn_n` low drives `dac_active` low. Entering or leaving shutdown does not change `dac_code`, and a load during shutdown is still accepted.
- R8: An `sclk` rising edge seen in the same sampled cycle as the rise of `cs_n` is not counted. A transfer of 8 pulses with a coincident ninth edge commits. A transfer of 7 pulses with a coincident eighth edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial shift clock |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| shdn_n | input | 1 | Active-low shutdown |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for the readback pad driver |
| dac_code | output | 8 | Held DAC code |
| dac_active | output | 1 | High when the analog DAC should be on |

## Verification
The interesting collision is the release of the select landing in the same sampled cycle as an edge of the shift clock. In that cycle, committing the word and counting a bit compete. The bench raises `sclk` and `cs_n` on the same instant, once after eight full pulses and once after seven. It judges the outcome only by whether `dac_code` took the new word: it must in the first case and must not in the second. A second overlap, a load while in shutdown, is judged by the code reading back intact once shutdown ends.

// File: rtl/serial_dac_reg.sv
module serial_dac_reg #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RESET_CODE = {1'b1, {(DATA_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              shdn_n,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_active
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, sdi_sy, shdn_sy;
  logic sclk_q, cs_q;
  logic [DATA_W:0] chain;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      sdi_sy  <= '0;
      shdn_sy <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      sclk_sy <= SYNC_STAGES'({sclk_sy, sclk});
      cs_sy   <= SYNC_STAGES'({cs_sy, cs_n});
      sdi_sy  <= SYNC_STAGES'({sdi_sy, sdi});
      shdn_sy <= SYNC_STAGES'({shdn_sy, shdn_n});
      sclk_q  <= sclk_sy[SYNC_STAGES-1];
      cs_q    <= cs_sy[SYNC_STAGES-1];
    end

  wire sclk_s    = sclk_sy[SYNC_STAGES-1];
  wire cs_s      = cs_sy[SYNC_STAGES-1];
  wire sdi_s     = sdi_sy[SYNC_STAGES-1];
  wire sclk_rise = sclk_s & ~sclk_q;
  wire sclk_fall = ~sclk_s & sclk_q;
  wire cs_fall   = ~cs_s & cs_q;
  wire cs_rise   = cs_s & ~cs_q;
  wire selected  = ~cs_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chain <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      chain <= {dac_code[DATA_W-1], dac_code};
      cnt   <= '0;
    end else if (selected) begin
      if (sclk_rise) begin
        chain[DATA_W-1:0] <= {chain[DATA_W-2:0], sdi_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
      if (sclk_fall) chain[DATA_W] <= chain[DATA_W-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dac_code <= RESET_CODE;
    else if (cs_rise && cnt == CNT_FULL) dac_code <= chain[DATA_W-1:0];

  assign sdo_oe     = selected;
  assign sdo        = selected & chain[DATA_W];
  assign dac_active = shdn_sy[SYNC_STAGES-1];

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_q) |=> $stable(dac_code));

  // R3
  commit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> ($past(cs_rise) && $past(cnt) == CNT_FULL));

  // R5
  sdo_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && $past(selected) && !$past(sclk_fall)) |-> $stable(chain[DATA_W]));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);

  // R6
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> (!sdo_oe && !sdo));
endmodule

// File: tb/serial_dac_reg_tb.sv
module serial_dac_reg_tb;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0, shdn_n = 1;
  logic sdo, sdo_oe, dac_active;
  logic [7:0] dac_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_code = 8'h80;
  localparam int PH = 6;

  // {word, pulses, commit}
  localparam logic [12:0] VEC [8] = '{
    {8'hA5, 4'd8, 1'b1}, {8'h3C, 4'd8, 1'b1}, {8'hFF, 4'd7, 1'b0},
    {8'h00, 4'd9, 1'b0}, {8'h00, 4'd8, 1'b1}, {8'h81, 4'd8, 1'b1},
    {8'h5A, 4'd0, 1'b0}, {8'h7E, 4'd8, 1'b1}};

  always #10 clk = ~clk;

  serial_dac_reg u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdi(sdi), .shdn_n(shdn_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .dac_code(dac_code), .dac_active(dac_active));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(logic [7:0] w, int n, bit coincide, bit commit);
    logic [7:0] old = exp_code;
    cs_n = 0;
    wt(PH);
    chk("R6 oe on select", {7'd0, sdo_oe}, 8'd1);
    chk("R5 first readback bit", {7'd0, sdo}, {7'd0, old[7]});
    for (int i = 0; i < n; i++) begin
      sdi = (i < 8) ? w[7-i] : 1'b0;
      wt(PH);
      sclk = 1;
      wt(PH);
      sclk = 0;
      wt(PH);
      if (i < 7) chk("R5 readback bit", {7'd0, sdo}, {7'd0, old[6-i]});
    end
    if (coincide) begin
      sclk = 1;
      cs_n = 1;
      wt(PH);
      sclk = 0;
    end else cs_n = 1;
    wt(PH);
    chk("R6 oe off", {6'd0, sdo_oe, sdo}, 8'd0);
    if (commit) exp_code = w;
    chk(commit ? "R2 commit" : "R3 discard", dac_code, exp_code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wt(3);
    // R1
    chk("R1 reset code", dac_code, 8'h80);
    chk("R1 reset outputs", {5'd0, sdo_oe, sdo, dac_active}, 8'd0);
    rst_n = 1;
    wt(PH);
    chk("R1 code after release", dac_code, 8'h80);
    chk("R7 active when not shut down", {7'd0, dac_active}, 8'd1);

    foreach (VEC[k]) xfer(VEC[k][12:5], int'(VEC[k][4:1]), 1'b0, VEC[k][0]);

    // R4: toggling with select high
    for (int i = 0; i < 8; i++) begin
      sdi = ~sdi;
      wt(PH);
      sclk = 1;
      wt(PH);
      sclk = 0;
      chk("R6 oe low while idle", {6'd0, sdo_oe, sdo}, 8'd0);
    end
    wt(PH);
    chk("R4 idle clocks ignored", dac_code, exp_code);

    // R8: coincident edge with release
    xfer(8'hC3, 8, 1'b1, 1'b1);
    xfer(8'h18, 7, 1'b1, 1'b0);

    // R7: shutdown retention
    shdn_n = 0;
    wt(PH);
    chk("R7 dac off", {7'd0, dac_active}, 8'd0);
    chk("R7 code kept on entry", dac_code, exp_code);
    xfer(8'h96, 8, 1'b0, 1'b1);
    shdn_n = 1;
    wt(PH);
    chk("R7 dac back on", {7'd0, dac_active}, 8'd1);
    chk("R7 code kept on exit", dac_code, 8'h96);
    xfer(8'h42, 8, 1'b0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule